// File: doc/BRIEF.md
# Segmented circular queue pointer manager

This block keeps the read and write pointers for a small set of output queues that share one 32K-entry message buffer. Software gives each queue a region field (address bits 14:10) and a first and a last 32-entry segment (address bits 9:5) inside that region. A queue therefore holds between 32 and 1024 entries in steps of 32, and it never crosses a 1024-entry boundary. The buffer itself lives outside this block.

On each cycle the block accepts at most one push and one pop request, each tagged with a queue number. For each accepted request it returns the 15-bit physical buffer address: the write slot for a push and the read slot for a pop. It also advances the matching pointer. When a pointer moves past the last entry of the last segment, it reloads to entry 0 of the first segment. The block counts the occupancy of every queue and reports full and empty for each one. A push that is refused and a pop that is refused each set a sticky per-queue flag.

Top module: `segq_ptr_mgr`

## Requirements
- R1: After reset, every queue is configured with region 0, first segment 0 and last segment 0. Every queue is empty and not full, both pointers are at offset 0, and the overflow, underflow and configuration-error flags are low.
- R2: A push to a queue that is not full is accepted in the same cycle (push_acc high). push_addr equals {region, tail offset}, where the offset is 10 bits and the region forms bits 14:10. The tail then advances by one entry.
- R3: An accepted pop returns in pop_addr the address written by the oldest push that has not yet been popped, so pops follow push order.
- R4: When a pointer at offset {last segment, 5'd31} advances, it reloads to {first segment, 5'd0}.
- R5: q_full[q] is high exactly when the occupancy of queue q equals (last minus first plus 1) times 32. q_empty[q] is high exactly when the occupancy is 0.
- R6: A push to a full queue has push_acc low and leaves the queue unchanged. It sets q_ovf[q], which stays high until that queue is configured again.
- R7: A pop from an empty queue has pop_acc low and leaves the queue unchanged. It sets q_udf[q], which stays high until that queue is configured again.
- R8: A configuration write with last >= first loads the queue's fields. It places both pointers at {first, 5'd0}, clears the occupancy and clears that queue's overflow and underflow flags.
- R9: A configuration write with last < first is discarded, so the queue keeps its fields, pointers and count. cfg_err goes high for exactly the following cycle.
- R10: When a push and a pop target the same queue in one cycle, acceptance is judged on the occupancy before the cycle. If the queue is neither full nor empty, both are accepted and the count stays unchanged. If it is full, only the pop is accepted and q_ovf is set. If it is empty, only the push is accepted and q_udf is set.
- R11: A configuration write, valid or not, to the queue that a push or pop targets in the same cycle blocks that push or pop: its acceptance is low and it sets no flag.
- R12: Operations on one queue leave every other queue's pointers, count and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | 4 | Queue being configured |
| cfg_base | input | 5 | Region field (address bits 14:10) |
| cfg_first | input | 5 | First segment (address bits 9:5) |
| cfg_last | input | 5 | Last segment (address bits 9:5) |
| cfg_err | output | 1 | One-cycle pulse after a rejected configuration |
| push_req | input | 1 | Push request |
| push_qid | input | 4 | Queue targeted by the push |
| push_acc | output | 1 | Push accepted this cycle |
| push_addr | output | 15 | Write address of the targeted queue |
| pop_req | input | 1 | Pop request |
| pop_qid | input | 4 | Queue targeted by the pop |
| pop_acc | output | 1 | Pop accepted this cycle |
| pop_addr | output | 15 | Read address of the targeted queue |
| q_full | output | 16 | Per-queue full |
| q_empty | output | 16 | Per-queue empty |
| q_ovf | output | 16 | Per-queue sticky overflow |
| q_udf | output | 16 | Per-queue sticky underflow |

## Verification
A push and a pop can land on the same queue in one cycle. A configuration write can also coincide with a push or pop to the queue it rewrites. The bench drives the same-queue push and pop pair on a queue that is partly filled, on one that is exactly full and on one that is empty. It then judges acceptance against the occupancy held before the cycle, and it checks that the count and both flags follow. Coincident configuration is provoked with both a valid and a rejected setting, and the bench checks that the blocked request neither moves a pointer nor raises a flag.

// File: rtl/segq_pkg.sv
package segq_pkg;
    localparam int ADDR_W = 15;
    localparam int IDX_W  = 5;
    localparam int SEG_W  = 5;
    localparam int REG_W  = ADDR_W - SEG_W - IDX_W;
    localparam int OFF_W  = SEG_W + IDX_W;
    localparam int CNT_W  = OFF_W + 1;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [SEG_W-1:0] first;
        logic [SEG_W-1:0] last;
    } qcfg_t;

    // Advance a pointer offset one entry, reloading at the last slot.
    function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] off,
                                                  input qcfg_t c);
        if (off == {c.last, {IDX_W{1'b1}}})
            return {c.first, {IDX_W{1'b0}}};
        return off + OFF_W'(1);
    endfunction

    // Number of entries the queue spans.
    function automatic logic [CNT_W-1:0] capacity(input qcfg_t c);
        logic [SEG_W:0] nseg;
        nseg = {1'b0, c.last} - {1'b0, c.first} + (SEG_W+1)'(1);
        return {nseg, {IDX_W{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] phys(input qcfg_t c,
                                               input logic [OFF_W-1:0] off);
        return {c.base, off};
    endfunction
endpackage

// File: rtl/segq_cfg_check.sv
module segq_cfg_check
    import segq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] first,
    input  logic [SEG_W-1:0] last,
    output logic             cfg_ok,
    output logic             cfg_err
);
    assign cfg_ok = (last >= first);

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= cfg_we && !cfg_ok;
    end

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (last < first)) |=> cfg_err);
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> !cfg_err);
endmodule

// File: rtl/segq_queue.sv
module segq_queue
    import segq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_hit,
    input  qcfg_t             cfg_in,
    input  logic              push_req,
    input  logic              pop_req,
    output logic              push_acc,
    output logic              pop_acc,
    output logic [ADDR_W-1:0] tail_addr,
    output logic [ADDR_W-1:0] head_addr,
    output logic              full,
    output logic              empty,
    output logic              ovf,
    output logic              udf
);
    qcfg_t             cfg_q;
    logic [OFF_W-1:0]  tail_q, head_q;
    logic [CNT_W-1:0]  cnt_q;

    assign full      = (cnt_q == capacity(cfg_q));
    assign empty     = (cnt_q == '0);
    assign push_acc  = push_req && !full;
    assign pop_acc   = pop_req && !empty;
    assign tail_addr = phys(cfg_q, tail_q);
    assign head_addr = phys(cfg_q, head_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            tail_q <= '0;
            head_q <= '0;
            cnt_q  <= '0;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else if (cfg_hit) begin
            cfg_q  <= cfg_in;
            tail_q <= {cfg_in.first, {IDX_W{1'b0}}};
            head_q <= {cfg_in.first, {IDX_W{1'b0}}};
            cnt_q  <= '0;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else begin
            if (push_acc) tail_q <= next_off(tail_q, cfg_q);
            if (pop_acc)  head_q <= next_off(head_q, cfg_q);
            case ({push_acc, pop_acc})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (push_req && full)  ovf <= 1'b1;
            if (pop_req  && empty) udf <= 1'b1;
        end
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= capacity(cfg_q));
    assert_tail_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (tail_q[OFF_W-1:IDX_W] >= cfg_q.first) && (tail_q[OFF_W-1:IDX_W] <= cfg_q.last));
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !cfg_hit) |=> ($stable(tail_q) && ovf));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty && !cfg_hit) |=> ($stable(head_q) && udf));
    assert_cfg_reload_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_hit |=> (tail_q == head_q) && empty && !ovf && !udf);
    assert_pair_keeps_count_R10: assert property (@(posedge clk) disable iff (rst)
        (push_acc && pop_acc && !cfg_hit) |=> $stable(cnt_q));
endmodule

// File: rtl/segq_ptr_mgr.sv
module segq_ptr_mgr
    import segq_pkg::*;
#(
    parameter int NUM_Q = 16,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [QW-1:0]     cfg_qid,
    input  logic [REG_W-1:0]  cfg_base,
    input  logic [SEG_W-1:0]  cfg_first,
    input  logic [SEG_W-1:0]  cfg_last,
    output logic              cfg_err,
    input  logic              push_req,
    input  logic [QW-1:0]     push_qid,
    output logic              push_acc,
    output logic [ADDR_W-1:0] push_addr,
    input  logic              pop_req,
    input  logic [QW-1:0]     pop_qid,
    output logic              pop_acc,
    output logic [ADDR_W-1:0] pop_addr,
    output logic [NUM_Q-1:0]  q_full,
    output logic [NUM_Q-1:0]  q_empty,
    output logic [NUM_Q-1:0]  q_ovf,
    output logic [NUM_Q-1:0]  q_udf
);
    logic              cfg_ok;
    qcfg_t             cfg_in;
    logic [NUM_Q-1:0]  push_acc_v, pop_acc_v;
    logic [ADDR_W-1:0] tail_a [NUM_Q];
    logic [ADDR_W-1:0] head_a [NUM_Q];

    assign cfg_in = '{base: cfg_base, first: cfg_first, last: cfg_last};

    segq_cfg_check u_chk (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .first(cfg_first), .last(cfg_last),
        .cfg_ok(cfg_ok), .cfg_err(cfg_err)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic cfg_sel, psh, pp;
        assign cfg_sel = cfg_we && (cfg_qid == QW'(q));
        assign psh     = push_req && (push_qid == QW'(q)) && !cfg_sel;
        assign pp      = pop_req  && (pop_qid  == QW'(q)) && !cfg_sel;

        segq_queue u_q (
            .clk(clk), .rst(rst),
            .cfg_hit(cfg_sel && cfg_ok), .cfg_in(cfg_in),
            .push_req(psh), .pop_req(pp),
            .push_acc(push_acc_v[q]), .pop_acc(pop_acc_v[q]),
            .tail_addr(tail_a[q]), .head_addr(head_a[q]),
            .full(q_full[q]), .empty(q_empty[q]),
            .ovf(q_ovf[q]), .udf(q_udf[q])
        );
    end

    assign push_acc  = |push_acc_v;
    assign pop_acc   = |pop_acc_v;
    assign push_addr = tail_a[push_qid];
    assign pop_addr  = head_a[pop_qid];

    assert_cfg_blocks_push_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && push_req && (cfg_qid == push_qid)) |-> !push_acc);
    assert_cfg_blocks_pop_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && pop_req && (cfg_qid == pop_qid)) |-> !pop_acc);
    assert_one_push_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push_acc_v));
endmodule

// File: tb/tb_segq_ptr_mgr.sv
module tb_segq_ptr_mgr;
    localparam int PERIOD = 10;
    localparam int NQ = 16;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic rst, cfg_we, cfg_err, push_req, push_acc, pop_req, pop_acc;
    logic [3:0] cfg_qid, push_qid, pop_qid;
    logic [4:0] cfg_base, cfg_first, cfg_last;
    logic [14:0] push_addr, pop_addr;
    logic [NQ-1:0] q_full, q_empty, q_ovf, q_udf;

    segq_ptr_mgr dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int mb[NQ], ms[NQ], me[NQ], mt[NQ], mh[NQ], mc[NQ];
    bit mo[NQ], mu[NQ];
    logic [14:0] sbq[NQ][$];

    function automatic int cap(int q);
        return (me[q] - ms[q] + 1) * 32;
    endfunction
    function automatic int nxt(int q, int p);
        if (p == me[q]*32 + 31) return ms[q]*32;
        return p + 1;
    endfunction

    task automatic chk_eq(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic status(string r);
        for (int q = 0; q < NQ; q++) begin
            chk_eq(r, q_full[q],  mc[q] == cap(q));
            chk_eq(r, q_empty[q], mc[q] == 0);
            chk_eq(r, q_ovf[q],   mo[q]);
            chk_eq(r, q_udf[q],   mu[q]);
        end
    endtask

    // Driver: applies one cycle, predicts acceptance and addresses and
    // feeds the scoreboard; the pop side acts as monitor against it.
    task automatic op(bit pv, int pq, bit ov, int oq,
                      bit cw, int cq, int cb, int cs, int ce, string r);
        bit blkp, blko, ep, eo, eerr;
        int ex;
        push_req = pv; push_qid = 4'(pq);
        pop_req  = ov; pop_qid  = 4'(oq);
        cfg_we = cw; cfg_qid = 4'(cq);
        cfg_base = 5'(cb); cfg_first = 5'(cs); cfg_last = 5'(ce);
        #1;
        blkp = cw && cq == pq;
        blko = cw && cq == oq;
        ep = pv && !blkp && mc[pq] != cap(pq);
        eo = ov && !blko && mc[oq] != 0;
        chk_eq(r, push_acc, ep);
        chk_eq(r, pop_acc, eo);
        if (ep) begin
            chk_eq(r, push_addr, mb[pq]*1024 + mt[pq]);
            sbq[pq].push_back(15'(mb[pq]*1024 + mt[pq]));
        end
        if (eo) begin
            ex = sbq[oq].pop_front();
            chk_eq(r, pop_addr, ex);
        end
        if (pv && !blkp && !ep) mo[pq] = 1;
        if (ov && !blko && !eo) mu[oq] = 1;
        if (ep) begin mt[pq] = nxt(pq, mt[pq]); mc[pq]++; end
        if (eo) begin mh[oq] = nxt(oq, mh[oq]); mc[oq]--; end
        eerr = cw && ce < cs;
        if (cw && ce >= cs) begin
            mb[cq] = cb; ms[cq] = cs; me[cq] = ce;
            mt[cq] = cs*32; mh[cq] = cs*32; mc[cq] = 0;
            mo[cq] = 0; mu[cq] = 0; sbq[cq].delete();
        end
        @(posedge clk); @(negedge clk);
        chk_eq(r, cfg_err, eerr);
        push_req = 0; pop_req = 0; cfg_we = 0;
    endtask

    task automatic push(int q, string r); op(1, q, 0, 0, 0, 0, 0, 0, 0, r); endtask
    task automatic pop(int q, string r);  op(0, 0, 1, q, 0, 0, 0, 0, 0, r); endtask
    task automatic cfg(int q, int b, int s, int e, string r); op(0, 0, 0, 0, 1, q, b, s, e, r); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int q = 0; q < NQ; q++) begin
            mb[q] = 0; ms[q] = 0; me[q] = 0; mt[q] = 0; mh[q] = 0; mc[q] = 0; mo[q] = 0; mu[q] = 0;
        end
        rst = 1; cfg_we = 0; push_req = 0; pop_req = 0;
        cfg_qid = 0; push_qid = 0; pop_qid = 0; cfg_base = 0; cfg_first = 0; cfg_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        // R1: reset state
        status("R1");
        chk_eq("R1", push_addr, 0);
        chk_eq("R1", cfg_err, 0);

        // R8 / R2: configure queue 1 (region 3, segments 2..3, 64 entries)
        cfg(1, 3, 2, 3, "R8");
        status("R8");
        for (int i = 0; i < 40; i++) push(1, "R2");
        for (int i = 0; i < 40; i++) pop(1, "R3");
        // R4: tail crosses the last entry of segment 3 and reloads to segment 2
        for (int i = 0; i < 30; i++) push(1, "R4");
        chk_eq("R4", mt[1], 64 + 6);
        for (int i = 0; i < 34; i++) push(1, "R5");
        status("R5");
        push(1, "R6");
        status("R6");
        // R10 at full: pop taken, push refused
        op(1, 1, 1, 1, 0, 0, 0, 0, 0, "R10");
        status("R10");
        for (int i = 0; i < 63; i++) pop(1, "R3");
        pop(1, "R7");
        status("R7");
        // R10 at empty: push taken, pop refused
        op(1, 1, 1, 1, 0, 0, 0, 0, 0, "R10");
        // R10 partial: paired ops keep count
        for (int i = 0; i < 5; i++) push(1, "R10");
        for (int i = 0; i < 70; i++) op(1, 1, 1, 1, 0, 0, 0, 0, 0, "R10");
        status("R10");
        // R8: reconfigure clears flags and pointers
        cfg(1, 7, 31, 31, "R8");
        status("R8");
        push(1, "R8");
        // R9: bad setting on queue 2 is refused
        push(2, "R9");
        cfg(2, 9, 5, 4, "R9");
        status("R9");
        push(2, "R9");
        pop(2, "R9");
        // R11: coinciding configuration blocks push and pop
        cfg(4, 1, 0, 1, "R11");
        push(4, "R11"); push(4, "R11");
        op(1, 4, 1, 4, 1, 4, 2, 4, 6, "R11");
        status("R11");
        push(4, "R11");
        op(1, 4, 1, 4, 1, 4, 2, 6, 4, "R11");
        status("R11");
        pop(4, "R11");
        // R12: queues are independent
        cfg(5, 10, 0, 0, "R12");
        cfg(6, 11, 8, 9, "R12");
        for (int i = 0; i < 32; i++) op(1, 5, 1, 6, 0, 0, 0, 0, 0, "R12");
        push(5, "R12");
        for (int i = 0; i < 10; i++) op(1, 6, 1, 5, 0, 0, 0, 0, 0, "R12");
        status("R12");
        finish_run();
    end
endmodule